// File: doc/BRIEF.md
# Commit-Gated Store Queue

This block is a circular queue of stores that sits between execution and the data cache. A store takes a slot at the tail when it is dispatched. The slot index is handed back so that execution can later fill in the address, data and byte size. Stores stay put until the commit stage reports the sequence number of the youngest retired instruction. From then on they are eligible and are written to the cache strictly in queue order, one per cycle, over a valid/ready request port.

Three pointers walk the ring. The head marks the oldest occupied slot, the writeback pointer marks the next slot to send, and the tail marks the next free slot. Each request carries its slot index as a tag. Completion acknowledgements return that tag in any order. The head steps over the whole run of completed slots in a single cycle. A store with zero data size never reaches the cache: it completes as soon as the writeback pointer reaches it.

A squash trims uncommitted stores back from the tail. The storage holds one slot more than the usable depth, and the free count given to dispatch also takes the load side's free count into account.

Top module: `store_queue`

## Requirements
- R1: After reset all three pointers are at slot 0: `alloc_idx_o` is 0, `req_valid_o` is 0, and `free_o` equals DEPTH when `lq_free_i` is at least DEPTH+1.
- R2: An accepted allocation takes the slot given by `alloc_idx_o` and moves the tail forward by one modulo DEPTH+1. An allocation is ignored when DEPTH slots are occupied or when `squash_i` is high in the same cycle.
- R3: A commit walks from the head over the slots that are not yet eligible and marks each one whose sequence number is at most `commit_seq_i` (unsigned compare). The walk stops at the first such slot with a larger number, and slots after it stay unmarked even when they are older.
- R4: A request is raised for the slot at the writeback pointer when that slot is eligible, occupied and has a nonzero size. It is raised in the cycle after the commit edge, `req_tag_o` equals the slot index, and slots are sent in queue order, at most one per cycle.
- R5: An eligible slot with size 0 raises no request. It is completed and skipped in one cycle.
- R6: A request that is not accepted stays asserted with unchanged tag, address, data and size until `req_ready_i` is high. No later slot is sent before it.
- R7: `ack_i` with `ack_tag_i` completes that slot in any order. The head advances only over a contiguous run of completed slots starting at the head, and `free_o` rises by the length of that run in the next cycle.
- R8: `squash_i` removes slots backward from the tail while their sequence number is greater than `squash_seq_i` and they are not eligible. It stops at the first eligible slot or the first slot with a number at or below `squash_seq_i`, and the tail moves back by the number removed.
- R9: `free_o` equals min(`lq_free_i`, DEPTH+1 − occupancy) − 1 combinationally. `lq_free_i` counts the load side's free slots including its spare slot, so it is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_i | input | 1 | Allocate a slot at the tail |
| alloc_seq_i | input | SEQ_W | Sequence number of the allocated store |
| alloc_idx_o | output | IDX_W | Slot index the next allocation receives |
| wr_i | input | 1 | Write address, data and size into a slot |
| wr_idx_i | input | IDX_W | Slot to write |
| wr_addr_i | input | ADDR_W | Store address |
| wr_data_i | input | DATA_W | Store data |
| wr_size_i | input | SIZE_W | Store size in bytes, 0 means no data |
| commit_i | input | 1 | Commit notification |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_i | input | 1 | Squash younger uncommitted stores |
| squash_seq_i | input | SEQ_W | Stores numbered above this are squashed |
| req_valid_o | output | 1 | Cache write request valid |
| req_ready_i | input | 1 | Cache accepts the request |
| req_tag_o | output | IDX_W | Slot index of the request |
| req_addr_o | output | ADDR_W | Request address |
| req_data_o | output | DATA_W | Request data |
| req_size_o | output | SIZE_W | Request size |
| ack_i | input | 1 | Completion acknowledgement |
| ack_tag_i | input | IDX_W | Slot being completed |
| lq_free_i | input | LQ_W | Load-side free slots including its spare |
| free_o | output | CNT_W | Entries dispatch may still allocate |

## Verification
`free_o` and the request outputs are built from registered state. A result of allocate, commit, acknowledge or squash is therefore due one clock edge after the stimulus. `free_o` additionally follows `lq_free_i` in the same cycle, with no edge in between. The bench applies each stimulus for exactly one edge, drops it one time unit later, and samples a further time unit after that. The check therefore sees the state produced by that one edge and nothing from the next.

Chains of events are followed one edge at a time. One such chain is a request accepted at one edge, a zero-size skip at the next edge, and a head retirement only at the edge of the acknowledgement. A refused request is sampled again after every stalled edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
  function automatic int unsigned ring_fwd(int unsigned p, int unsigned k, int unsigned n);
    return (p + k) % n;
  endfunction

  function automatic int unsigned ring_back(int unsigned p, int unsigned k, int unsigned n);
    return (p + n - (k % n)) % n;
  endfunction
endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic                        en_i,
  input  logic [IDX_W-1:0]            head_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq_i,
  input  logic [SLOTS-1:0]            elig_i,
  input  logic [SEQ_W-1:0]            lim_i,
  output logic [SLOTS-1:0]            mark_o,
  output logic [CNT_W-1:0]            nmark_o
);
  import sq_pkg::*;

  always_comb begin
    logic stop;
    logic [IDX_W-1:0] idx;
    mark_o  = '0;
    nmark_o = '0;
    stop    = !en_i;
    for (int unsigned k = 0; k < SLOTS; k++) begin
      idx = IDX_W'(ring_fwd(32'(head_i), k, SLOTS));
      // already-eligible slots are passed over, first younger one ends the walk
      if (!stop && (k < 32'(cnt_i)) && !elig_i[idx]) begin
        if (seq_i[idx] <= lim_i) begin
          mark_o[idx] = 1'b1;
          nmark_o     = nmark_o + CNT_W'(1);
        end else begin
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic                        en_i,
  input  logic [IDX_W-1:0]            tail_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq_i,
  input  logic [SLOTS-1:0]            elig_i,
  input  logic [SEQ_W-1:0]            lim_i,
  output logic [SLOTS-1:0]            rm_o,
  output logic [CNT_W-1:0]            nrm_o
);
  import sq_pkg::*;

  always_comb begin
    logic stop;
    logic [IDX_W-1:0] idx;
    rm_o  = '0;
    nrm_o = '0;
    stop  = !en_i;
    for (int unsigned k = 0; k < SLOTS; k++) begin
      idx = IDX_W'(ring_back(32'(tail_i), k + 1, SLOTS));
      if (!stop && (k < 32'(cnt_i))) begin
        // eligible slots are committed and must survive
        if (!elig_i[idx] && (seq_i[idx] > lim_i)) begin
          rm_o[idx] = 1'b1;
          nrm_o     = nrm_o + CNT_W'(1);
        end else begin
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sq_retire_scan.sv
module sq_retire_scan #(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SLOTS-1:0] done_i,
  output logic [SLOTS-1:0] ret_o,
  output logic [CNT_W-1:0] nret_o
);
  import sq_pkg::*;

  always_comb begin
    logic run;
    logic [IDX_W-1:0] idx;
    ret_o  = '0;
    nret_o = '0;
    run    = 1'b1;
    for (int unsigned k = 0; k < SLOTS; k++) begin
      idx = IDX_W'(ring_fwd(32'(head_i), k, SLOTS));
      if (run && (k < 32'(cnt_i)) && done_i[idx]) begin
        ret_o[idx] = 1'b1;
        nret_o     = nret_o + CNT_W'(1);
      end else begin
        run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int LQ_W   = 4,
  localparam int SLOTS = DEPTH + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic              commit_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              squash_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [IDX_W-1:0]  req_tag_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic [SIZE_W-1:0] req_size_o,
  input  logic              ack_i,
  input  logic [IDX_W-1:0]  ack_tag_i,
  input  logic [LQ_W-1:0]   lq_free_i,
  output logic [CNT_W-1:0]  free_o
);
  import sq_pkg::*;

  localparam int FW = (LQ_W > CNT_W) ? LQ_W : CNT_W;

  logic [IDX_W-1:0] head_q, wb_q, tail_q;
  logic [CNT_W-1:0] pend_q;
  logic [SLOTS-1:0] elig_q, done_q;
  logic [SLOTS-1:0][SEQ_W-1:0]  seq_q;
  logic [SLOTS-1:0][ADDR_W-1:0] addr_q;
  logic [SLOTS-1:0][DATA_W-1:0] data_q;
  logic [SLOTS-1:0][SIZE_W-1:0] size_q;

  logic [CNT_W-1:0] cnt;
  logic             alloc_ok, wb_hit, wb_zero, fire;
  logic [SLOTS-1:0] comp_set, done_nx, elig_nx, mark, ret, rm;
  logic [CNT_W-1:0] nmark, nret, nrm;
  logic [1:0]       ncomp;

  assign cnt = (tail_q >= head_q) ? CNT_W'(tail_q - head_q)
                                  : CNT_W'(SLOTS) + CNT_W'(tail_q) - CNT_W'(head_q);

  assign alloc_ok = alloc_i && !squash_i && (cnt < CNT_W'(DEPTH));
  assign alloc_idx_o = tail_q;

  // writeback port: one slot per cycle from the writeback pointer
  assign wb_hit  = (pend_q != '0) && (wb_q != tail_q) && elig_q[wb_q];
  assign wb_zero = wb_hit && (size_q[wb_q] == '0);
  assign req_valid_o = wb_hit && !wb_zero;
  assign fire        = req_valid_o && req_ready_i;
  assign req_tag_o   = wb_q;
  assign req_addr_o  = addr_q[wb_q];
  assign req_data_o  = data_q[wb_q];
  assign req_size_o  = size_q[wb_q];

  always_comb begin
    comp_set = '0;
    if (wb_zero) comp_set[wb_q] = 1'b1;
    if (ack_i)   comp_set[ack_tag_i] = 1'b1;
  end
  assign ncomp   = {1'b0, wb_zero} + {1'b0, ack_i};
  assign done_nx = done_q | comp_set;
  assign elig_nx = elig_q | mark;

  sq_commit_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_commit (
    .en_i(commit_i), .head_i(head_q), .cnt_i(cnt), .seq_i(seq_q), .elig_i(elig_q),
    .lim_i(commit_seq_i), .mark_o(mark), .nmark_o(nmark)
  );

  sq_retire_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_retire (
    .head_i(head_q), .cnt_i(cnt), .done_i(done_nx), .ret_o(ret), .nret_o(nret)
  );

  sq_squash_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_squash (
    .en_i(squash_i), .tail_i(tail_q), .cnt_i(cnt), .seq_i(seq_q), .elig_i(elig_nx),
    .lim_i(squash_seq_i), .rm_o(rm), .nrm_o(nrm)
  );

  // free count, lq side includes its spare slot
  logic [FW-1:0] lq_w, sq_w, min_w;
  assign lq_w   = FW'(lq_free_i);
  assign sq_w   = FW'(CNT_W'(SLOTS) - cnt);
  assign min_w  = (lq_w < sq_w) ? lq_w : sq_w;
  assign free_o = CNT_W'(min_w - FW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      wb_q   <= '0;
      tail_q <= '0;
      pend_q <= '0;
      elig_q <= '0;
      done_q <= '0;
    end else begin
      head_q <= IDX_W'(ring_fwd(32'(head_q), 32'(nret), SLOTS));
      if (wb_zero || fire) wb_q <= IDX_W'(ring_fwd(32'(wb_q), 1, SLOTS));
      if (squash_i)      tail_q <= IDX_W'(ring_back(32'(tail_q), 32'(nrm), SLOTS));
      else if (alloc_ok) tail_q <= IDX_W'(ring_fwd(32'(tail_q), 1, SLOTS));
      pend_q <= pend_q + nmark - CNT_W'(ncomp);
      elig_q <= elig_nx & ~ret & ~rm;
      done_q <= done_nx & ~ret & ~rm;
      if (alloc_ok) begin
        elig_q[tail_q] <= 1'b0;
        done_q[tail_q] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq_i;
    if (wr_i) begin
      addr_q[wr_idx_i] <= wr_addr_i;
      data_q[wr_idx_i] <= wr_data_i;
      size_q[wr_idx_i] <= wr_size_i;
    end
  end
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  pend_q,
  input logic [IDX_W-1:0]  head_q,
  input logic [IDX_W-1:0]  wb_q,
  input logic [IDX_W-1:0]  tail_q,
  input logic              alloc_i,
  input logic              squash_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [IDX_W-1:0]  req_tag_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_data_o,
  input logic [SIZE_W-1:0] req_size_o
);
  localparam int SLOTS = DEPTH + 1;

  function automatic int unsigned gap(logic [IDX_W-1:0] a, logic [IDX_W-1:0] b);
    return (32'(b) + SLOTS - 32'(a)) % SLOTS;
  endfunction

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt) <= DEPTH);

  a_r2_full_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(cnt) == DEPTH && alloc_i && !squash_i) |=> $stable(tail_q));

  a_r6_hold_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_tag_o) &&
      $stable(req_addr_o) && $stable(req_data_o) && $stable(req_size_o)));

  a_r8_wb_within_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap(head_q, wb_q) <= 32'(cnt));

  a_r3_pending_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= cnt);
endmodule

bind store_queue sq_checker #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_sq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt(cnt), .pend_q(pend_q),
  .head_q(head_q), .wb_q(wb_q), .tail_q(tail_q),
  .alloc_i(alloc_i), .squash_i(squash_i),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_tag_o(req_tag_o),
  .req_addr_o(req_addr_o), .req_data_o(req_data_o), .req_size_o(req_size_o)
);

// File: tb/store_queue_tb.sv
module store_queue_tb;
  localparam int DEPTH = 4;
  localparam int IDX_W = 3;
  localparam int CNT_W = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_i = 1'b0;
  logic [7:0]  alloc_seq_i = '0;
  logic [2:0]  alloc_idx_o;
  logic        wr_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [15:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  wr_size_i = '0;
  logic        commit_i = 1'b0;
  logic [7:0]  commit_seq_i = '0;
  logic        squash_i = 1'b0;
  logic [7:0]  squash_seq_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [2:0]  req_tag_o;
  logic [15:0] req_addr_o;
  logic [31:0] req_data_o;
  logic [3:0]  req_size_o;
  logic        ack_i = 1'b0;
  logic [2:0]  ack_tag_i = '0;
  logic [3:0]  lq_free_i = 4'd15;
  logic [2:0]  free_o;

  int ntest = 0;
  int nfail = 0;

  always #2 clk_i = ~clk_i;

  store_queue #(.DEPTH(DEPTH)) u_dut (
    .clk_i, .rst_ni, .alloc_i, .alloc_seq_i, .alloc_idx_o,
    .wr_i, .wr_idx_i, .wr_addr_i, .wr_data_i, .wr_size_i,
    .commit_i, .commit_seq_i, .squash_i, .squash_seq_i,
    .req_valid_o, .req_ready_i, .req_tag_o, .req_addr_o, .req_data_o, .req_size_o,
    .ack_i, .ack_tag_i, .lq_free_i, .free_o
  );

  task automatic chk(string req, int act, int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge with the pulses set beforehand, then sample between edges
  task automatic cyc();
    @(posedge clk_i);
    #1;
    alloc_i = 1'b0; wr_i = 1'b0; commit_i = 1'b0; squash_i = 1'b0; ack_i = 1'b0;
    #1;
  endtask

  task automatic do_alloc(int seq);
    alloc_i = 1'b1; alloc_seq_i = 8'(seq); cyc();
  endtask

  task automatic do_wr(int idx, int addr, int data, int size);
    wr_i = 1'b1; wr_idx_i = 3'(idx); wr_addr_i = 16'(addr);
    wr_data_i = 32'(data); wr_size_i = 4'(size); cyc();
  endtask

  task automatic do_commit(int seq);
    commit_i = 1'b1; commit_seq_i = 8'(seq); cyc();
  endtask

  task automatic do_ack(int tag);
    ack_i = 1'b1; ack_tag_i = 3'(tag); cyc();
  endtask

  task automatic send_one();
    req_ready_i = 1'b1; cyc(); req_ready_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    ntest++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    chk("R1 free", int'(free_o), DEPTH);
    chk("R1 req_valid", int'(req_valid_o), 0);
    chk("R1 alloc_idx", int'(alloc_idx_o), 0);

    // R2 fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(10 * (i + 1));
      chk("R2 alloc_idx", int'(alloc_idx_o), i + 1);
      chk("R2 free", int'(free_o), DEPTH - 1 - i);
    end
    do_alloc(50);
    chk("R2 full alloc_idx", int'(alloc_idx_o), 4);
    chk("R2 full free", int'(free_o), 0);

    for (int i = 0; i < DEPTH; i++)
      do_wr(i, 'h100 + i, 'hA0 + i, (i == 1) ? 0 : ((i == 2) ? 2 : 4));
    chk("R3 nothing committed", int'(req_valid_o), 0);

    do_commit(25);
    chk("R4 valid", int'(req_valid_o), 1);
    chk("R4 tag", int'(req_tag_o), 0);
    chk("R4 addr", int'(req_addr_o), 'h100);
    chk("R4 data", int'(req_data_o), 'hA0);
    chk("R4 size", int'(req_size_o), 4);
    for (int i = 0; i < 2; i++) begin
      cyc();
      chk("R6 held valid", int'(req_valid_o), 1);
      chk("R6 held tag", int'(req_tag_o), 0);
      chk("R6 held addr", int'(req_addr_o), 'h100);
    end
    send_one();
    chk("R5 zero size no request", int'(req_valid_o), 0);
    cyc();
    chk("R3 younger not eligible", int'(req_valid_o), 0);
    chk("R7 head waits for ack", int'(free_o), 0);
    do_ack(0);
    chk("R7 run of two retired", int'(free_o), 2);

    do_commit(40);
    chk("R4 valid 2", int'(req_valid_o), 1);
    chk("R4 tag 2", int'(req_tag_o), 2);
    chk("R4 addr 2", int'(req_addr_o), 'h102);
    chk("R4 size 2", int'(req_size_o), 2);
    req_ready_i = 1'b1; cyc();
    chk("R4 order tag 3", int'(req_tag_o), 3);
    chk("R4 order valid", int'(req_valid_o), 1);
    cyc(); req_ready_i = 1'b0;
    chk("R4 drained", int'(req_valid_o), 0);
    do_ack(3);
    chk("R7 out of order no retire", int'(free_o), 2);
    do_ack(2);
    chk("R7 both retired", int'(free_o), 4);

    // R8 squash against a committed slot
    do_alloc(50);
    chk("R2 wrap idx", int'(alloc_idx_o), 0);
    do_alloc(60);
    do_alloc(70);
    chk("R2 idx 2", int'(alloc_idx_o), 2);
    chk("R2 free 1", int'(free_o), 1);
    do_wr(4, 'h150, 'h55, 4);
    do_wr(0, 'h160, 'h66, 4);
    do_wr(1, 'h170, 'h77, 4);
    do_commit(55);
    chk("R4 tag 4", int'(req_tag_o), 4);
    squash_i = 1'b1; squash_seq_i = 8'd40; alloc_i = 1'b1; alloc_seq_i = 8'd99;
    cyc();
    chk("R8 tail back", int'(alloc_idx_o), 0);
    chk("R8 free", int'(free_o), 3);
    chk("R2 alloc ignored on squash", int'(free_o), 3);
    chk("R8 committed survives", int'(req_tag_o), 4);
    chk("R8 committed valid", int'(req_valid_o), 1);
    chk("R8 committed addr", int'(req_addr_o), 'h150);
    send_one();
    do_ack(4);
    chk("R7 empty again", int'(free_o), 4);

    // R3 walk stops at first younger slot
    do_alloc(100);
    do_alloc(130);
    do_alloc(120);
    for (int i = 0; i < 3; i++) do_wr(i, 'h200 + i, 'hB0 + i, 4);
    do_commit(125);
    chk("R3 oldest sent", int'(req_tag_o), 0);
    send_one();
    chk("R3 stopped at younger", int'(req_valid_o), 0);
    do_ack(0);
    chk("R7 free 2", int'(free_o), 2);
    do_commit(200);
    chk("R3 tag 1", int'(req_tag_o), 1);
    req_ready_i = 1'b1; cyc();
    chk("R3 tag 2", int'(req_tag_o), 2);
    cyc(); req_ready_i = 1'b0;
    chk("R4 none left", int'(req_valid_o), 0);
    do_ack(2);
    chk("R7 hole at head", int'(free_o), 2);
    do_ack(1);
    chk("R7 all retired", int'(free_o), 4);

    // R8 stop at an older slot
    do_alloc(210);
    do_alloc(220);
    do_alloc(230);
    squash_i = 1'b1; squash_seq_i = 8'd215; cyc();
    chk("R8 partial tail", int'(alloc_idx_o), 4);
    chk("R8 partial free", int'(free_o), 3);
    squash_i = 1'b1; squash_seq_i = 8'd0; cyc();
    chk("R8 full tail", int'(alloc_idx_o), 3);
    chk("R8 full free", int'(free_o), 4);

    // R9 free count sweep against the load side
    for (int lq = 1; lq <= 7; lq++) begin
      lq_free_i = 4'(lq);
      #1;
      chk("R9 empty min", int'(free_o), ((lq < DEPTH + 1) ? lq : DEPTH + 1) - 1);
    end
    lq_free_i = 4'd3;
    do_alloc(240);
    chk("R9 lq limits", int'(free_o), 2);
    lq_free_i = 4'd15;
    #1;
    chk("R9 sq limits", int'(free_o), DEPTH - 1);

    finish_run();
  end
endmodule